// File: doc/BRIEF.md
# Strobed Receive-FIFO Burst Read Slave

This block sits between an asynchronous host read bus and a receive data FIFO inside a synchronous clock domain. The host pulls FIFO words out one per strobe cycle, with no address phase between words. It drives an active-low chip select, an active-low read enable and a select line that steers reads to the FIFO. The block brings these pins into its clock domain through flop synchronisers. It finds where each read cycle begins and ends, and it holds the head word on the data pins for the length of the cycle. The data pins are driven through per-half output enables, and the enables go to tri-state pads outside the block.

A cycle exists only while both strobes are low and the select line is high. The strobes may go low and return high in any order. A cycle can be any length, and cycles can follow one another without limit. The FIFO is popped once at the end of each cycle. This means a cycle that the host cuts short still uses up exactly one word. In 16-bit mode the upper data half is never enabled. Each FIFO word is returned in two cycles, low half first, and it is popped after its high half has been read. A read from an empty FIFO returns a filler pattern, does not pop, and sets a sticky underrun flag.

Top module: `rxf_burst_slave`

## Requirements
- R1: An access cycle is recognised only while `cs_ni` and `rd_ni` are both low and `fsel_i` is high. One strobe low on its own never enables the data outputs and never pops the FIFO.
- R2: The two strobes may fall and rise in either order. The cycle ends when the first of them rises. The output enables drop combinationally at that same moment, with no clock edge needed.
- R3: Each completed cycle produces exactly one single-clock `fifo_pop_o` pulse. The pulse comes three clock edges after the strobe rise that ended the cycle. Nothing is popped when a cycle starts. A short cycle still pops one word, provided its overlap spans at least three clock edges.
- R4: While `fsel_i` is low, strobe activity leaves `data_lo_oe_o` and `data_hi_oe_o` low and does not pop the FIFO.
- R5: Back-to-back cycles, separated only by short strobe-high gaps of a few clocks, each return the next FIFO word in order.
- R6: With `bus16_i` low, the head word appears on `data_o[31:0]` by the third clock edge after the later strobe falls. Both output enables are high for the rest of the cycle, and the data stays stable while the cycle lasts.
- R7: With `bus16_i` high, `data_hi_oe_o` stays low. The first cycle on a word returns bits 15:0 of that word on `data_o[15:0]`, and the next cycle returns bits 31:16. The word is popped only after the cycle that returned its upper half.
- R8: A cycle that starts while `fifo_empty_i` is high returns `FILL_WORD` (its low half in 16-bit mode), does not pop, does not advance the half pointer, and sets `underrun_o`.
- R9: `underrun_o` stays set until a clock edge with `underrun_clr_i` high clears it. A new underrun on that same edge keeps it set.
- R10: After reset, both output enables, `fifo_pop_o` and `underrun_o` are low, and the half pointer selects the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Host chip select, active low, asynchronous |
| rd_ni | input | 1 | Host read enable, active low, asynchronous |
| fsel_i | input | 1 | Steers reads to the receive FIFO when high |
| bus16_i | input | 1 | High selects 16-bit bus mode |
| underrun_clr_i | input | 1 | Clears the sticky underrun flag |
| fifo_data_i | input | 32 | FIFO head word |
| fifo_empty_i | input | 1 | FIFO holds no word |
| fifo_pop_o | output | 1 | One-clock pop request |
| data_o | output | 32 | Read data toward the pads |
| data_lo_oe_o | output | 1 | Output enable for data bits 15:0 |
| data_hi_oe_o | output | 1 | Output enable for data bits 31:16 |
| underrun_o | output | 1 | Sticky flag for a read from an empty FIFO |

## Verification
The case that is hardest to reach from the ports is the 16-bit half pointer after an underrun. An empty read must neither pop nor flip the pointer, so the next real word must still start with its low half. To get there, the bench first reads one low half in 16-bit mode and its matching high half. It then drains the FIFO to empty, reads once from the empty FIFO, pushes a fresh word, and checks that the next two cycles return that word's low half and then its high half, with exactly one pop. The strobe ordering is covered by cycles that lower chip select first, lower read enable first, and end on either strobe. The output enables are sampled one nanosecond after the first strobe rises.

// File: rtl/rxf_burst_pkg.sv
package rxf_burst_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = WORD_W / 2;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [HALF_W-1:0] half_t;

  // select the half that goes out on a 16-bit bus
  function automatic word_t narrow(input word_t w, input logic upper);
    return {{HALF_W{1'b0}}, (upper ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0])};
  endfunction
endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rxf_cycle_det.sv
module rxf_cycle_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_s_ni,
  input  logic rd_s_ni,
  input  logic fsel_s_i,
  output logic act_o,
  output logic start_o,
  output logic end_o
);
  logic act_s, act_q;

  assign act_s = ~cs_s_ni & ~rd_s_ni & fsel_s_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act_s;

  assign act_o   = act_q;
  assign start_o = act_s & ~act_q;
  assign end_o   = ~act_s & act_q;

  // R2
  edge_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R1
  start_needs_strobes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (!cs_s_ni && !rd_s_ni && fsel_s_i));
endmodule

// File: rtl/rxf_read_ctrl.sv
module rxf_read_ctrl
  import rxf_burst_pkg::*;
#(
  parameter word_t FILL_WORD = 32'hBAD0_F11D
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  act_i,
  input  logic  start_i,
  input  logic  end_i,
  input  logic  bus16_i,
  input  logic  underrun_clr_i,
  input  word_t fifo_data_i,
  input  logic  fifo_empty_i,
  output word_t data_o,
  output logic  pop_o,
  output logic  underrun_o
);
  word_t data_q;
  logic  half_q, cyc_empty_q, pop_q, underrun_q;
  logic  last_part;

  // a word is consumed on 32-bit cycles, or after its upper half in 16-bit
  assign last_part = ~bus16_i | half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q      <= '0;
      half_q      <= 1'b0;
      cyc_empty_q <= 1'b0;
      pop_q       <= 1'b0;
      underrun_q  <= 1'b0;
    end else begin
      pop_q <= 1'b0;
      if (start_i) begin
        cyc_empty_q <= fifo_empty_i;
        if (fifo_empty_i) data_q <= bus16_i ? narrow(FILL_WORD, 1'b0) : FILL_WORD;
        else              data_q <= bus16_i ? narrow(fifo_data_i, half_q) : fifo_data_i;
      end
      if (end_i && !cyc_empty_q) begin
        pop_q  <= last_part;
        half_q <= bus16_i & ~half_q;
      end else if (!bus16_i) begin
        half_q <= 1'b0;
      end
      underrun_q <= (underrun_q & ~underrun_clr_i) | (start_i & fifo_empty_i);
    end
  end

  assign data_o     = data_q;
  assign pop_o      = pop_q;
  assign underrun_o = underrun_q;

  // R3
  pop_one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_q |=> !pop_q);
  // R3
  pop_after_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_q |-> $past(end_i));
  // R8
  no_pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_q |-> $past(!cyc_empty_q));
  // R6
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && $past(act_i)) |-> $stable(data_q));
  // R7
  half_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_q && bus16_i && $past(bus16_i)) |-> !half_q);
  // R9
  underrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_q && !underrun_clr_i) |=> underrun_q);
endmodule

// File: rtl/rxf_burst_slave.sv
module rxf_burst_slave
  import rxf_burst_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter word_t       FILL_WORD   = 32'hBAD0_F11D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              fsel_i,
  input  logic              bus16_i,
  input  logic              underrun_clr_i,
  input  logic [WORD_W-1:0] fifo_data_i,
  input  logic              fifo_empty_i,
  output logic              fifo_pop_o,
  output logic [WORD_W-1:0] data_o,
  output logic              data_lo_oe_o,
  output logic              data_hi_oe_o,
  output logic              underrun_o
);
  logic [2:0] pins_s;
  logic       act, start_p, end_p, pin_act;

  rxf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, rd_ni, fsel_i}),
    .q_o   (pins_s)
  );

  rxf_cycle_det u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_s_ni (pins_s[2]),
    .rd_s_ni (pins_s[1]),
    .fsel_s_i(pins_s[0]),
    .act_o   (act),
    .start_o (start_p),
    .end_o   (end_p)
  );

  rxf_read_ctrl #(.FILL_WORD(FILL_WORD)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .act_i         (act),
    .start_i       (start_p),
    .end_i         (end_p),
    .bus16_i       (bus16_i),
    .underrun_clr_i(underrun_clr_i),
    .fifo_data_i   (fifo_data_i),
    .fifo_empty_i  (fifo_empty_i),
    .data_o        (data_o),
    .pop_o         (fifo_pop_o),
    .underrun_o    (underrun_o)
  );

  // raw pin term turns the driver off without waiting for the synchroniser
  assign pin_act      = ~cs_ni & ~rd_ni & fsel_i;
  assign data_lo_oe_o = act & pin_act;
  assign data_hi_oe_o = act & pin_act & ~bus16_i;

  // R4
  no_oe_unselected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fsel_i |-> !data_lo_oe_o);
  // R7
  hi_oe_off16_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_hi_oe_o |-> data_lo_oe_o);
endmodule

// File: tb/rxf_burst_slave_tb.sv
module rxf_burst_slave_tb;
  localparam logic [31:0] FILL = 32'hBAD0_F11D;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, fsel = 1'b1, bus16 = 1'b0, uclr = 1'b0;
  logic [31:0] fdata, dout;
  logic fempty, pop, oe_lo, oe_hi, urun;

  logic [31:0] mem [16];
  int wr_p = 0, rd_p = 0, pops = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign fempty = (wr_p == rd_p);
  assign fdata  = mem[rd_p % 16];

  always @(posedge clk) if (pop) begin rd_p <= rd_p + 1; pops <= pops + 1; end

  rxf_burst_slave #(.FILL_WORD(FILL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .fsel_i(fsel),
    .bus16_i(bus16), .underrun_clr_i(uclr), .fifo_data_i(fdata),
    .fifo_empty_i(fempty), .fifo_pop_o(pop), .data_o(dout),
    .data_lo_oe_o(oe_lo), .data_hi_oe_o(oe_hi), .underrun_o(urun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    mem[wr_p % 16] = w;
    wr_p++;
  endtask

  // order: 0 both together, 1 cs first, 2 rd first; ends rd first when odd
  task automatic rd_cycle(input int order, input int gap,
                          output logic [31:0] d, output logic lo, output logic hi,
                          output logic off);
    @(negedge clk);
    case (order)
      1: begin cs_n = 1'b0; repeat (2) @(negedge clk); rd_n = 1'b0; end
      2: begin rd_n = 1'b0; repeat (2) @(negedge clk); cs_n = 1'b0; end
      default: begin cs_n = 1'b0; rd_n = 1'b0; end
    endcase
    repeat (4) @(negedge clk);
    d = dout; lo = oe_lo; hi = oe_hi;
    if (order % 2 == 1) rd_n = 1'b1; else cs_n = 1'b1;
    #1 off = oe_lo | oe_hi;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 oe_lo", {31'b0, oe_lo}, 0);
    chk("R10 oe_hi", {31'b0, oe_hi}, 0);
    chk("R10 pop", {31'b0, pop}, 0);
    chk("R10 underrun", {31'b0, urun}, 0);
  endtask

  task automatic t_single_strobe;
    int p0 = pops;
    push(32'h1111_2222);
    @(negedge clk); cs_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R1 cs alone oe", {31'b0, oe_lo}, 0);
    cs_n = 1'b1; rd_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R1 rd alone oe", {31'b0, oe_lo}, 0);
    rd_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 no pop", pops - p0, 0);
  endtask

  task automatic t_orders32;
    logic [31:0] d; logic lo, hi, off;
    int p0;
    push(32'hA5A5_0001); push(32'hA5A5_0002);
    for (int o = 0; o < 3; o++) begin
      logic [31:0] exp = mem[rd_p % 16];
      p0 = pops;
      rd_cycle(o, 5, d, lo, hi, off);
      chk("R6 data32", d, exp);
      chk("R6 both oe", {30'b0, lo, hi}, 2'b11);
      chk("R2 oe drops at strobe rise", {31'b0, off}, 0);
      chk("R3 one pop", pops - p0, 1);
    end
  endtask

  task automatic t_fsel_low;
    logic [31:0] d; logic lo, hi, off;
    int p0 = pops;
    push(32'hCAFE_0003);
    fsel = 1'b0;
    rd_cycle(0, 5, d, lo, hi, off);
    fsel = 1'b1;
    chk("R4 no oe", {30'b0, lo, hi}, 0);
    chk("R4 no pop", pops - p0, 0);
  endtask

  task automatic t_burst;
    logic [31:0] d; logic lo, hi, off;
    int p0;
    while (!fempty) begin
      rd_cycle(0, 5, d, lo, hi, off);
    end
    for (int i = 0; i < 8; i++) push(32'h5000_0000 + i * 32'h0101);
    p0 = pops;
    for (int i = 0; i < 8; i++) begin
      rd_cycle(i % 3, 2, d, lo, hi, off);
      chk("R5 burst word", d, 32'h5000_0000 + i * 32'h0101);
    end
    repeat (4) @(negedge clk);
    chk("R5 burst pops", pops - p0, 8);
  endtask

  task automatic t_bus16;
    logic [31:0] d; logic lo, hi, off;
    int p0 = pops;
    bus16 = 1'b1;
    push(32'h1234_5678); push(32'h9ABC_DEF0);
    rd_cycle(1, 5, d, lo, hi, off);
    chk("R7 low half", d, 32'h0000_5678);
    chk("R7 hi oe off", {31'b0, hi}, 0);
    chk("R7 no pop after low half", pops - p0, 0);
    rd_cycle(2, 5, d, lo, hi, off);
    chk("R7 high half", d, 32'h0000_1234);
    chk("R7 pop after high half", pops - p0, 1);
    rd_cycle(0, 5, d, lo, hi, off);
    chk("R7 next low half", d, 32'h0000_DEF0);
    rd_cycle(0, 5, d, lo, hi, off);
    chk("R7 next high half", d, 32'h0000_9ABC);
    chk("R7 two pops", pops - p0, 2);
  endtask

  task automatic t_underrun;
    logic [31:0] d; logic lo, hi, off;
    int p0 = pops;
    rd_cycle(0, 5, d, lo, hi, off);
    chk("R8 fill16", d, {16'h0, FILL[15:0]});
    chk("R8 no pop", pops - p0, 0);
    chk("R8 underrun set", {31'b0, urun}, 1);
    push(32'hFACE_B00C);
    rd_cycle(0, 5, d, lo, hi, off);
    chk("R8 half ptr kept", d, 32'h0000_B00C);
    rd_cycle(0, 5, d, lo, hi, off);
    chk("R8 upper after underrun", d, 32'h0000_FACE);
    chk("R8 one pop", pops - p0, 1);
    chk("R9 still set", {31'b0, urun}, 1);
    @(negedge clk); uclr = 1'b1; @(negedge clk); uclr = 1'b0;
    chk("R9 cleared", {31'b0, urun}, 0);
    bus16 = 1'b0;
    rd_cycle(2, 5, d, lo, hi, off);
    chk("R8 fill32", d, FILL);
    chk("R9 set again", {31'b0, urun}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single_strobe();
    t_orders32();
    t_fsel_low();
    t_burst();
    t_bus16();
    t_underrun();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule